// File: doc/BRIEF.md
# Interrupt Preemption Comparator With Capture

This block sits between an interrupt priority arbiter and one processor. Each cycle it compares the highest pending priority from the arbiter with the processor's current priority. It raises a registered request line whenever the pending priority is strictly greater than the current priority. A rising pending priority and a falling current priority both raise the request.

The block also holds a vector and priority pair for an acknowledge register. It captures the first interrupt that beats the current priority. In hardware vectoring mode that capture stays locked until it is cleared. In software vectoring mode, a higher-priority arrival replaces it until an acknowledge arrives. The captured priority is the value to load into the current priority register when the request is acknowledged. An acknowledge or a current-priority update clears the capture-valid flag, and the next qualifying interrupt is then captured.

Top module: `irq_preempt_cmp`

## Requirements
- R1: `irq` is high in the cycle after an edge at which `pend_pri > cur_pri` (unsigned, strict) and low otherwise; equal priorities never request.
- R2: Lowering `cur_pri` below an unchanged `pend_pri` raises `irq` one cycle later.
- R3: A pending priority of 0 never raises `irq`.
- R4: When `cap_valid` is low and `pend_pri > cur_pri`, the next edge loads `cap_vec`/`cap_pri` from `pend_vec`/`pend_pri` and sets `cap_valid`; `cap_pri` is the value for the current priority register on acknowledge.
- R5: With `hw_mode` = 1, a valid capture is not replaced by any later arrival, even one of higher priority.
- R6: With `hw_mode` = 0, a valid capture is replaced by an arrival whose priority exceeds both `cap_pri` and `cur_pri`; an arrival of equal or lower priority does not replace it.
- R7: `ack` or `cur_upd` high at an edge clears `cap_valid` and leaves `cap_vec`/`cap_pri` unchanged; a qualifying interrupt is captured again afterwards.
- R8: When a clear (`ack` or `cur_upd`) and a qualifying interrupt fall at the same edge, the clear wins; the capture happens at the next edge if the interrupt still qualifies.
- R9: After reset, `irq`, `cap_vec`, `cap_pri` and `cap_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_pri | input | 4 | Highest pending priority from the arbiter |
| pend_vec | input | 8 | Vector of the highest pending interrupt |
| cur_pri | input | 4 | Current processor priority |
| hw_mode | input | 1 | 1 = hardware vectoring, 0 = software vectoring |
| ack | input | 1 | Acknowledge strobe |
| cur_upd | input | 1 | Current-priority update strobe |
| irq | output | 1 | Registered interrupt request |
| cap_vec | output | 8 | Captured vector |
| cap_pri | output | 4 | Captured priority (value to load into the current priority on acknowledge) |
| cap_valid | output | 1 | Capture holds a valid entry |

## Verification
A clear strobe and a qualifying capture can fall at the same edge. In software mode this can be a higher-priority arrival that would otherwise replace the capture. The bench drives `ack` in the same cycle as a new, higher pending priority. It expects `cap_valid` low after that edge, with the old vector still present. It then expects the new vector to be captured one edge later, while `irq` follows the comparison at both edges.

// File: rtl/irq_preempt_cmp.sv
module irq_preempt_cmp #(
  parameter int PW = 4,
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] pend_pri,
  input  logic [VW-1:0] pend_vec,
  input  logic [PW-1:0] cur_pri,
  input  logic          hw_mode,
  input  logic          ack,
  input  logic          cur_upd,
  output logic          irq,
  output logic [VW-1:0] cap_vec,
  output logic [PW-1:0] cap_pri,
  output logic          cap_valid
);

  logic wins, clr, beats_cap, load;

  assign wins      = pend_pri > cur_pri;
  assign clr       = ack | cur_upd;
  assign beats_cap = ~hw_mode & (pend_pri > cap_pri);
  assign load      = ~clr & wins & (~cap_valid | beats_cap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= wins;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_vec   <= '0;
      cap_pri   <= '0;
      cap_valid <= 1'b0;
    end else if (clr) begin
      cap_valid <= 1'b0;
    end else if (load) begin
      cap_vec   <= pend_vec;
      cap_pri   <= pend_pri;
      cap_valid <= 1'b1;
    end
  end

endmodule

// File: rtl/irq_preempt_cmp_chk.sv
module irq_preempt_cmp_chk #(
  parameter int PW = 4,
  parameter int VW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [PW-1:0] pend_pri,
  input logic [VW-1:0] pend_vec,
  input logic [PW-1:0] cur_pri,
  input logic          hw_mode,
  input logic          ack,
  input logic          cur_upd,
  input logic          irq,
  input logic [VW-1:0] cap_vec,
  input logic [PW-1:0] cap_pri,
  input logic          cap_valid
);

  assert_irq_needs_win_R1: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(pend_pri > cur_pri));

  assert_irq_follows_win_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_pri > cur_pri) |=> irq);

  assert_zero_never_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_pri == '0) |=> !irq);

  assert_capture_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_valid && !ack && !cur_upd && pend_pri > cur_pri) |=>
      (cap_valid && cap_pri == $past(pend_pri) && cap_vec == $past(pend_vec)));

  assert_hw_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_mode && cap_valid && !ack && !cur_upd) |=> ($stable(cap_vec) && $stable(cap_pri) && cap_valid));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack || cur_upd) |=> (!cap_valid && $stable(cap_vec) && $stable(cap_pri)));

endmodule

bind irq_preempt_cmp irq_preempt_cmp_chk #(.PW(PW), .VW(VW)) i_chk (.*);

// File: tb/test_irq_preempt_cmp.sv
`timescale 1ns/1ps
module test_irq_preempt_cmp;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] pend_pri = '0;
  logic [7:0] pend_vec = '0;
  logic [3:0] cur_pri = '0;
  logic hw_mode = 1'b1, ack = 1'b0, cur_upd = 1'b0;
  logic irq, cap_valid;
  logic [7:0] cap_vec;
  logic [3:0] cap_pri;

  always #2 clk = ~clk;

  irq_preempt_cmp i_irq_preempt_cmp (.*);

  typedef struct {
    logic irq; logic [7:0] vec; logic [3:0] pri; logic val; string tag;
  } exp_t;

  exp_t q[$];
  int applied = 0, fails = 0;
  bit done = 0;

  logic m_irq = 0, m_val = 0;
  logic [7:0] m_vec = '0;
  logic [3:0] m_pri = '0;

  task automatic apply(input logic [3:0] p, input logic [7:0] v, input logic [3:0] c,
                       input logic hw, input logic a, input logic u, input string tag);
    exp_t e;
    @(negedge clk);
    pend_pri = p; pend_vec = v; cur_pri = c; hw_mode = hw; ack = a; cur_upd = u;
    m_irq = (p > c);
    if (a || u) m_val = 0;
    else if (p > c && (!m_val || (!hw && p > m_pri))) begin
      m_vec = v; m_pri = p; m_val = 1;
    end
    e.irq = m_irq; e.vec = m_vec; e.pri = m_pri; e.val = m_val; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        applied++;
        if (irq !== e.irq || cap_vec !== e.vec || cap_pri !== e.pri || cap_valid !== e.val) begin
          fails++;
          $display("FAIL %s: got irq=%b vec=%h pri=%0d val=%b, expected irq=%b vec=%h pri=%0d val=%b",
                   e.tag, irq, cap_vec, cap_pri, cap_valid, e.irq, e.vec, e.pri, e.val);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    applied++;
    if (irq !== 0 || cap_vec !== 0 || cap_pri !== 0 || cap_valid !== 0) begin
      fails++;
      $display("FAIL R9: got irq=%b vec=%h pri=%0d val=%b, expected all zero", irq, cap_vec, cap_pri, cap_valid);
    end
    @(negedge clk) rst_n = 1'b1;
    apply(4'd3,  8'h10, 4'd5, 1, 0, 0, "R1 below");
    apply(4'd5,  8'h11, 4'd5, 1, 0, 0, "R1 equal");
    apply(4'd6,  8'h21, 4'd5, 1, 0, 0, "R4 first capture");
    apply(4'd9,  8'h33, 4'd5, 1, 0, 0, "R5 hw no replace");
    apply(4'd9,  8'h33, 4'd9, 1, 0, 1, "R7 update clears");
    apply(4'd12, 8'h44, 4'd9, 1, 0, 0, "R7 recapture");
    apply(4'd7,  8'h45, 4'd7, 1, 0, 0, "R2 equal first");
    apply(4'd7,  8'h45, 4'd3, 1, 0, 0, "R2 lowered current");
    apply(4'd0,  8'h46, 4'd0, 1, 1, 0, "R3 zero with ack");
    apply(4'd0,  8'h47, 4'd0, 0, 0, 0, "R3 zero idle");
    apply(4'd4,  8'h01, 4'd0, 0, 0, 0, "R4 sw capture");
    apply(4'd8,  8'h02, 4'd0, 0, 0, 0, "R6 sw replace");
    apply(4'd6,  8'h03, 4'd0, 0, 0, 0, "R6 lower kept");
    apply(4'd8,  8'h05, 4'd0, 0, 0, 0, "R6 equal kept");
    apply(4'd10, 8'h04, 4'd0, 0, 1, 0, "R8 ack wins");
    apply(4'd10, 8'h04, 4'd0, 0, 0, 0, "R8 capture after");
    apply(4'd13, 8'h06, 4'd2, 1, 0, 1, "R8 update wins hw");
    apply(4'd13, 8'h06, 4'd2, 1, 0, 0, "R8 hw capture after");
    apply(4'd15, 8'h07, 4'd2, 1, 0, 0, "R5 top priority locked");
    apply(4'd1,  8'h08, 4'd15, 1, 0, 0, "R1 current highest");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
      $finish;
    end
  end

endmodule